// File: doc/BRIEF.md
# Serial Byte Transmitter with Hold

This block turns one parallel byte into an asynchronous-style serial frame on a single output line. A writer places a byte on the parallel input and raises the valid strobe for a cycle. The block captures the byte at that clock edge and sends it out one bit per clock. Each frame is a low start bit, then the eight data bits with the least significant bit first, then a high stop bit.

While a frame is on the line, the hold output is high. The writer must not offer another byte until hold drops. If it does, the strobe is ignored. Between frames the line rests high. There is no baud divider, so each bit lasts exactly one system clock. A full frame therefore takes ten clocks.

Top module: `ser_byte_tx`

## Requirements
- R1: While reset is high at a clock edge, serial_out is high and hold is low after that edge.
- R2: When no frame is being sent (hold low), serial_out is high.
- R3: When valid is high at an edge where hold is low, serial_out is low (the start bit) for the cycle after that edge.
- R4: In the eight cycles after the start bit, serial_out carries the captured byte, bit 0 first through bit 7 last, one bit per clock.
- R5: In the cycle after bit 7, serial_out is high (the stop bit).
- R6: hold rises in the cycle after the byte is accepted and stays high for exactly 10 cycles, covering the start bit, the data bits and the stop bit.
- R7: A valid strobe sampled while hold is high is ignored. The frame in flight continues unchanged and no extra frame follows it.
- R8: The byte is captured at the accepting edge. Changes on data_in during the frame do not alter the bits sent.
- R9: With valid held high continuously, a new frame starts once hold is low again. The gap is a single idle cycle with the line high, so a frame starts every 11 cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; one serial bit per period |
| rst | input | 1 | Synchronous reset, active high |
| data_in | input | 8 | Parallel byte to send |
| valid | input | 1 | Byte offer strobe, sampled at the rising edge |
| serial_out | output | 1 | Serial line, high when idle |
| hold | output | 1 | High while a frame is in flight; writer must wait |

## Verification
Several kinds of byte are sent so that errors in bit order and data capture can be told apart:
- Single bytes with mixed values, such as 0xA5 and 0x3C, show whether the bit order is reversed. The all-zero and all-one bytes show whether the start and stop bits are distinguishable from the data.
- Strobes pulsed in the middle of a frame, together with data_in changing under an active frame, separate a correct capture from a design that re-samples its input.
- Valid held high across many frames shows the one-cycle gap between frames and the 11-cycle cadence. An off-by-one in the bit counter shows up there as a drifting frame boundary.
- Reset asserted in mid-frame checks that the line returns to idle at once.

// File: rtl/stx_pkg.sv
package stx_pkg;

    typedef enum logic {
        STX_IDLE = 1'b0,
        STX_SEND = 1'b1
    } stx_state_e;

    typedef struct packed {
        logic load;   // capture byte, start a frame
        logic shift;  // advance one bit on the line
    } stx_ctrl_t;

    // number of line bits in one frame: start + data + stop
    function automatic int frame_bits(input int data_w);
        return data_w + 2;
    endfunction

    function automatic int cnt_width(input int n);
        int w;
        w = 1;
        while ((1 << w) < n) w++;
        return w;
    endfunction

endpackage

// File: rtl/stx_sequencer.sv
module stx_sequencer
    import stx_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      valid,
    input  logic      last_bit,
    output stx_ctrl_t ctrl,
    output logic      busy
);

    stx_state_e state_q, state_d;

    always_comb begin
        state_d    = state_q;
        ctrl.load  = 1'b0;
        ctrl.shift = 1'b0;
        unique case (state_q)
            STX_IDLE: begin
                if (valid) begin
                    ctrl.load = 1'b1;
                    state_d   = STX_SEND;
                end
            end
            STX_SEND: begin
                ctrl.shift = 1'b1;
                if (last_bit) state_d = STX_IDLE;
            end
            default: state_d = STX_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= STX_IDLE;
        else     state_q <= state_d;
    end

    assign busy = (state_q == STX_SEND);

endmodule

// File: rtl/stx_bit_counter.sv
module stx_bit_counter
    import stx_pkg::*;
#(
    parameter int FRAME_LEN = 10
) (
    input  logic      clk,
    input  logic      rst,
    input  stx_ctrl_t ctrl,
    output logic      last_bit
);

    localparam int CW = cnt_width(FRAME_LEN);
    localparam logic [CW-1:0] LAST = CW'(FRAME_LEN - 1);

    logic [CW-1:0] pos_q;

    always_ff @(posedge clk) begin
        if (rst || ctrl.load) pos_q <= '0;
        else if (ctrl.shift)  pos_q <= pos_q + 1'b1;
    end

    assign last_bit = (pos_q == LAST);

endmodule

// File: rtl/stx_shifter.sv
module stx_shifter
    import stx_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  stx_ctrl_t         ctrl,
    input  logic [DATA_W-1:0] byte_in,
    output logic              line_bit
);

    localparam int FL = frame_bits(DATA_W);

    logic [FL-1:0] frame_q;

    // bit 0 drives the line; ones refill from the top so the line idles high
    always_ff @(posedge clk) begin
        if (rst)             frame_q <= '1;
        else if (ctrl.load)  frame_q <= {1'b1, byte_in, 1'b0};
        else if (ctrl.shift) frame_q <= {1'b1, frame_q[FL-1:1]};
    end

    assign line_bit = frame_q[0];

endmodule

// File: rtl/ser_byte_tx.sv
module ser_byte_tx
    import stx_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [DATA_W-1:0] data_in,
    input  logic              valid,
    output logic              serial_out,
    output logic              hold
);

    localparam int FRAME_LEN = frame_bits(DATA_W);

    stx_ctrl_t ctrl;
    logic      last_bit;
    logic      busy;

    stx_sequencer u_seq (
        .clk      (clk),
        .rst      (rst),
        .valid    (valid),
        .last_bit (last_bit),
        .ctrl     (ctrl),
        .busy     (busy)
    );

    stx_bit_counter #(.FRAME_LEN(FRAME_LEN)) u_cnt (
        .clk      (clk),
        .rst      (rst),
        .ctrl     (ctrl),
        .last_bit (last_bit)
    );

    stx_shifter #(.DATA_W(DATA_W)) u_shf (
        .clk      (clk),
        .rst      (rst),
        .ctrl     (ctrl),
        .byte_in  (data_in),
        .line_bit (serial_out)
    );

    assign hold = busy;

endmodule

// File: rtl/stx_checker.sv
module stx_checker #(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst,
    input logic [DATA_W-1:0] data_in,
    input logic              valid,
    input logic              serial_out,
    input logic              hold
);

    localparam int FL = DATA_W + 2;
    localparam int RW = $clog2(FL + 2);

    logic [RW-1:0]     run;
    logic [DATA_W-1:0] cap;

    always_ff @(posedge clk) begin
        if (rst)       run <= '0;
        else if (hold) run <= run + 1'b1;
        else           run <= '0;
        if (!hold && valid) cap <= data_in;
    end

    AST_RESET_IDLE: assert property (@(posedge clk)
        rst |=> (serial_out && !hold)); // R1

    AST_IDLE_HIGH: assert property (@(posedge clk) disable iff (rst)
        !hold |-> serial_out); // R2

    AST_START_LOW: assert property (@(posedge clk) disable iff (rst)
        (!hold && valid) |=> (hold && !serial_out)); // R3

    AST_DATA_ORDER: assert property (@(posedge clk) disable iff (rst)
        (hold && run >= RW'(1) && run <= RW'(DATA_W)) |-> (serial_out == cap[run - 1'b1])); // R4

    AST_STOP_HIGH: assert property (@(posedge clk) disable iff (rst)
        (hold && run == RW'(FL - 1)) |-> serial_out); // R5

    AST_HOLD_LEN: assert property (@(posedge clk) disable iff (rst)
        $fell(hold) |-> (run == RW'(FL))); // R6

    AST_NO_OVERRUN: assert property (@(posedge clk) disable iff (rst)
        hold |-> (run < RW'(FL))); // R7

endmodule

bind ser_byte_tx stx_checker #(.DATA_W(DATA_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .data_in    (data_in),
    .valid      (valid),
    .serial_out (serial_out),
    .hold       (hold)
);

// File: tb/sim_ser_byte_tx.sv
`timescale 1ns/1ps
module sim_ser_byte_tx;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] data_in = 8'h00;
    logic       valid = 1'b0;
    logic       serial_out;
    logic       hold;

    int n_cmp = 0;
    int n_bad = 0;
    int cycles = 0;
    bit done = 0;

    // reference model: queue of line bits still to appear
    bit q[$];
    bit model_rst;
    int frame_pos;   // index of current bit within frame, -1 when idle
    string phase = "R1";

    always #2 clk = ~clk;

    ser_byte_tx u0 (
        .clk        (clk),
        .rst        (rst),
        .data_in    (data_in),
        .valid      (valid),
        .serial_out (serial_out),
        .hold       (hold)
    );

    always @(posedge clk) begin
        cycles++;
        model_rst = rst;
        if (rst) begin
            q.delete();
            frame_pos = -1;
        end else if (q.size() != 0) begin
            void'(q.pop_front());
            frame_pos = (q.size() != 0) ? frame_pos + 1 : -1;
        end else if (valid) begin
            q.push_back(1'b0);
            for (int i = 0; i < 8; i++) q.push_back(data_in[i]);
            q.push_back(1'b1);
            frame_pos = 0;
        end
    end

    function automatic string bit_req(input int p);
        if (model_rst)    return "R1";
        if (p < 0)        return "R2";
        if (p == 0)       return "R3";
        if (p <= 8)       return "R4";
        return "R5";
    endfunction

    always @(negedge clk) begin
        bit exp_s, exp_h;
        if (!done && cycles > 0) begin
            exp_h = !model_rst && (q.size() != 0);
            exp_s = exp_h ? q[0] : 1'b1;
            n_cmp++;
            if (serial_out !== exp_s) begin
                n_bad++;
                $display("FAIL %s (%s) cycle %0d: serial_out actual %b expected %b",
                         bit_req(frame_pos), phase, cycles, serial_out, exp_s);
            end
            if (hold !== exp_h) begin
                n_bad++;
                $display("FAIL R6 (%s) cycle %0d: hold actual %b expected %b",
                         phase, cycles, hold, exp_h);
            end
        end
    end

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic send(input logic [7:0] b);
        @(negedge clk);
        data_in = b;
        valid   = 1'b1;
        @(negedge clk);
        valid   = 1'b0;
    endtask

    initial begin : watchdog
        wait (cycles > 100000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: run did not finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        wait_cyc(3);                       // R1: reset state checked every cycle
        rst = 1'b0;
        phase = "R2";
        wait_cyc(4);                       // R2: idle line

        phase = "R4";                      // R3 R4 R5 R6: single frames, mixed patterns
        send(8'hA5); wait_cyc(12);
        send(8'h3C); wait_cyc(12);
        send(8'h00); wait_cyc(12);
        send(8'hFF); wait_cyc(12);
        send(8'h01); wait_cyc(12);
        send(8'h80); wait_cyc(12);

        phase = "R7";                      // R7: strobes while hold high are ignored
        send(8'h5A);
        wait_cyc(2);
        data_in = 8'hC3; valid = 1'b1; @(negedge clk); valid = 1'b0;
        wait_cyc(4);
        data_in = 8'h99; valid = 1'b1; @(negedge clk); valid = 1'b0;
        wait_cyc(12);

        phase = "R8";                      // R8: data_in changes during frame
        send(8'h6D);
        for (int i = 0; i < 10; i++) begin
            data_in = 8'(i * 37 + 11);
            @(negedge clk);
        end
        wait_cyc(3);

        phase = "R9";                      // R9: valid held, one idle cycle between frames
        @(negedge clk);
        valid = 1'b1;
        for (int i = 0; i < 60; i++) begin
            data_in = 8'(i * 53 + 7);
            @(negedge clk);
        end
        valid = 1'b0;
        wait_cyc(14);

        phase = "R1";                      // R1: reset mid-frame
        send(8'hE7);
        wait_cyc(3);
        rst = 1'b1;
        wait_cyc(2);
        rst = 1'b0;
        phase = "R2";
        wait_cyc(5);
        send(8'h42); wait_cyc(12);

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule